// File: doc/BRIEF.md
# Six-Source Two-Level Interrupt Controller

This block gathers the interrupt requests of a small control processor and presents one request and one vector to the CPU core. There are six sources, in the polling order used at each level. Source 0 and source 2 are external pins. Source 1 and source 3 are timer overflows. Source 4 is the serial port. Source 5 combines the third timer with a third external pin. Each source has an enable bit, and a global enable sits on top of all of them. Each source also has a priority bit that places it in the high or the low level.

The external pins are active low and are sampled on a machine-cycle strobe. Pins 0 and 1 can each work in level mode or in falling-edge mode. In level mode the request follows the sampled pin. In edge mode a stored flag is set by a HIGH sample followed by a LOW sample. The third external pin is always edge-triggered. It sets its own flag only when it is enabled, and software clears that flag. Source 5 requests while either its timer flag or this edge flag is set. The two timer overflow flags are stored here and are cleared when their source is vectored. The serial receive and transmit flags come in as levels, and the controller never clears them.

When the CPU acknowledges, the controller does three things. It marks the level of the vectored source as in service and clears the flag of a self-clearing source. It also holds its vector index and address steady for the CPU to latch. A return-from-interrupt pulse closes the highest level that is in service. A high-level request can interrupt a low-level routine. Any other request waits until the levels it would nest under have returned.

Top module: `irq_ctrl6`

## Requirements
- R1: After reset, irq_req is 0, no level is in service and pend is 000000, with all pins idle HIGH.
- R2: With ext_type[n]=0 (level mode), pend[2n] equals the inverse of the pin value sampled at the last clock edge where mc_tick was 1. A pin change while mc_tick is 0 has no effect. An acknowledge does not clear the request.
- R3: With ext_type[n]=1 (edge mode), a HIGH sample followed by a LOW sample sets pend[2n]. The flag stays set after the pin returns HIGH and is cleared by the acknowledge that vectors source 2n.
- R4: A one-cycle pulse on tmr0_ovf sets pend[1], and a pulse on tmr1_ovf sets pend[3]. Each flag is cleared by the acknowledge that vectors its own source.
- R5: pend[4] is 1 whenever ser_rx or ser_tx is 1, and an acknowledge of source 4 leaves it set.
- R6: pend[5] is the OR of t2_flag and an edge flag. The edge flag is set by a HIGH sample followed by a LOW sample on ext2_n, but only while ext2_en is 1. Only exf2_clr clears it; an acknowledge does not.
- R7: A source can request only when its en_mask bit is 1 and glob_en is 1. pend still shows the flag when the source is masked.
- R8: Within one level, the lowest-numbered pending source wins. irq_idx gives its number, and irq_addr = 3 + 8*irq_idx (for example 0x1B for source 3 and 0x2B for source 5).
- R9: A pending source with its prio_hi bit set wins over every low-level source, whatever the source numbers.
- R10: A high-level request is raised while only the low level is in service. A request whose level is already in service, or which is below an active level, is held off. Each reti pulse clears the high in-service bit if it is set, and otherwise clears the low one.
- R11: An ack pulse while irq_req is 0 changes no in-service state and clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_tick | input | 1 | Machine-cycle strobe; the pins are sampled when it is 1 |
| ext_n | input | 2 | External request pins 0 and 1, active low |
| ext_type | input | 2 | Trigger mode per pin: 1 = falling edge, 0 = level |
| ext2_n | input | 1 | Third external pin, active low, edge-triggered |
| ext2_en | input | 1 | Lets ext2_n set the source-5 edge flag |
| exf2_clr | input | 1 | Software clear of the source-5 edge flag |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| ser_rx | input | 1 | Serial receive flag (level) |
| ser_tx | input | 1 | Serial transmit flag (level) |
| t2_flag | input | 1 | Third timer overflow flag (level) |
| en_mask | input | 6 | Per-source enable bits |
| glob_en | input | 1 | Global enable |
| prio_hi | input | 6 | Per-source high-level select |
| ack | input | 1 | Vector acknowledge strobe from the CPU |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Request to the CPU |
| irq_idx | output | 3 | Index of the winning source |
| irq_addr | output | 8 | Vector address of the winning source |
| pend | output | 6 | Raw request flag per source, before masking |

## Verification
Several rules are checked by assertions on every cycle. No request may be raised through a disabled source or a clear global enable, or while the high level is in service. The chosen index must always point at a source that is actually requesting. A stored edge flag must persist until something clears it. A stray acknowledge must leave the in-service state alone, and a return must close the high level first. Other behaviour can only be shown by the bench's scenarios. These include the order in which sources win within a level and the high-level override. They also include a preemption during a low-level routine followed by the return of both levels. The remaining cases are the difference between level and edge sampling, the tick gating, and the flags that survive an acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC     = 6;
  localparam int IDXW     = $clog2(NSRC);
  localparam int ADDRW    = 8;
  localparam int VEC_BASE = 3;
  localparam int VEC_STEP = 8;
  localparam int NEXT     = 2;

  // Source numbers in polling order
  localparam int SRC_X0  = 0;
  localparam int SRC_T0  = 1;
  localparam int SRC_X1  = 2;
  localparam int SRC_T1  = 3;
  localparam int SRC_SER = 4;
  localparam int SRC_T2  = 5;

  function automatic logic [IDXW-1:0] lowest_set(input logic [NSRC-1:0] m);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (m[i]) r = IDXW'(i);
    end
    return r;
  endfunction

  function automatic logic [ADDRW-1:0] vec_addr(input logic [IDXW-1:0] idx);
    return ADDRW'(VEC_BASE + VEC_STEP * int'(idx));
  endfunction
endpackage

// File: rtl/irq_ext_in.sv
module irq_ext_in (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic edge_en,
  input  logic clr,
  output logic flag,
  output logic fall
);
  logic smp_q;
  logic eflag_q;

  assign fall = tick & smp_q & ~pin_n & edge_en & edge_mode;
  assign flag = edge_mode ? eflag_q : ~smp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q   <= 1'b1;
      eflag_q <= 1'b0;
    end else begin
      if (tick) smp_q <= pin_n;
      if (fall) eflag_q <= 1'b1;
      else if (clr) eflag_q <= 1'b0;
    end
  end

  // R3: a stored edge flag persists until cleared
  assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && flag && !clr) |=> (flag || !edge_mode));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_vec,
  input  logic [NSRC-1:0] prio_hi,
  input  logic            isr_hi,
  input  logic            isr_lo,
  output logic            irq_req,
  output logic [IDXW-1:0] irq_idx,
  output logic            lvl_hi
);
  logic [NSRC-1:0] hi_m;
  logic [NSRC-1:0] lo_m;

  always_comb begin
    hi_m    = req_vec & prio_hi;
    lo_m    = req_vec & ~prio_hi;
    irq_req = 1'b0;
    irq_idx = '0;
    lvl_hi  = 1'b0;
    if ((|hi_m) && !isr_hi) begin
      irq_req = 1'b1;
      irq_idx = lowest_set(hi_m);
      lvl_hi  = 1'b1;
    end else if ((|lo_m) && !isr_hi && !isr_lo) begin
      irq_req = 1'b1;
      irq_idx = lowest_set(lo_m);
    end
  end

  // R8: the chosen index always names a requesting source
  assert_pick_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> req_vec[irq_idx]);
endmodule

// File: rtl/irq_isr_track.sv
module irq_isr_track (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_hi,
  input  logic reti,
  output logic isr_hi,
  output logic isr_lo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_hi <= 1'b0;
      isr_lo <= 1'b0;
    end else if (take) begin
      if (take_hi) isr_hi <= 1'b1;
      else isr_lo <= 1'b1;
    end else if (reti) begin
      if (isr_hi) isr_hi <= 1'b0;
      else isr_lo <= 1'b0;
    end
  end

  // R10: a return closes the high level first and leaves the low one
  assert_reti_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take && isr_hi) |=> (!isr_hi && isr_lo == $past(isr_lo)));
endmodule

// File: rtl/irq_ctrl6.sv
module irq_ctrl6
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_tick,
  input  logic [NEXT-1:0]  ext_n,
  input  logic [NEXT-1:0]  ext_type,
  input  logic             ext2_n,
  input  logic             ext2_en,
  input  logic             exf2_clr,
  input  logic             tmr0_ovf,
  input  logic             tmr1_ovf,
  input  logic             ser_rx,
  input  logic             ser_tx,
  input  logic             t2_flag,
  input  logic [NSRC-1:0]  en_mask,
  input  logic             glob_en,
  input  logic [NSRC-1:0]  prio_hi,
  input  logic             ack,
  input  logic             reti,
  output logic             irq_req,
  output logic [IDXW-1:0]  irq_idx,
  output logic [ADDRW-1:0] irq_addr,
  output logic [NSRC-1:0]  pend
);
  logic            ack_take;
  logic            lvl_hi;
  logic            isr_hi;
  logic            isr_lo;
  logic [NEXT-1:0] ext_flag;
  logic [NEXT-1:0] ext_fall;
  logic [NEXT-1:0] ext_clr;
  logic            exf2_flag;
  logic            exf2_fall;
  logic            tf0_q;
  logic            tf1_q;
  logic [NSRC-1:0] req_vec;

  assign ack_take = ack & irq_req;

  for (genvar g = 0; g < NEXT; g++) begin : g_ext
    assign ext_clr[g] = ack_take && (irq_idx == IDXW'(2 * g));
    irq_ext_in u_ext (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (mc_tick),
      .pin_n    (ext_n[g]),
      .edge_mode(ext_type[g]),
      .edge_en  (1'b1),
      .clr      (ext_clr[g]),
      .flag     (ext_flag[g]),
      .fall     (ext_fall[g])
    );
  end

  irq_ext_in u_ext2 (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (mc_tick),
    .pin_n    (ext2_n),
    .edge_mode(1'b1),
    .edge_en  (ext2_en),
    .clr      (exf2_clr),
    .flag     (exf2_flag),
    .fall     (exf2_fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tf0_q <= 1'b0;
      tf1_q <= 1'b0;
    end else begin
      if (tmr0_ovf) tf0_q <= 1'b1;
      else if (ack_take && irq_idx == IDXW'(SRC_T0)) tf0_q <= 1'b0;
      if (tmr1_ovf) tf1_q <= 1'b1;
      else if (ack_take && irq_idx == IDXW'(SRC_T1)) tf1_q <= 1'b0;
    end
  end

  always_comb begin
    pend          = '0;
    pend[SRC_X0]  = ext_flag[0];
    pend[SRC_T0]  = tf0_q;
    pend[SRC_X1]  = ext_flag[1];
    pend[SRC_T1]  = tf1_q;
    pend[SRC_SER] = ser_rx | ser_tx;
    pend[SRC_T2]  = t2_flag | exf2_flag;
  end

  assign req_vec = pend & en_mask & {NSRC{glob_en}};

  irq_prio_arb u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_vec(req_vec),
    .prio_hi(prio_hi),
    .isr_hi (isr_hi),
    .isr_lo (isr_lo),
    .irq_req(irq_req),
    .irq_idx(irq_idx),
    .lvl_hi (lvl_hi)
  );

  irq_isr_track u_isr (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (ack_take),
    .take_hi(lvl_hi),
    .reti   (reti),
    .isr_hi (isr_hi),
    .isr_lo (isr_lo)
  );

  assign irq_addr = vec_addr(irq_idx);

  // R7: no request through a disabled source or a clear global enable
  assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (glob_en && en_mask[irq_idx]));

  // R10: nothing nests under an active high-level routine
  assert_hi_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    isr_hi |-> !irq_req);

  // R4: an acknowledged timer 0 flag is gone on the next cycle
  assert_tf0_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && irq_idx == IDXW'(SRC_T0) && !tmr0_ovf) |=> !pend[SRC_T0]);

  // R11: a stray acknowledge leaves the in-service state alone
  assert_stray_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_req && !reti) |=> ($stable(isr_hi) && $stable(isr_lo)));
endmodule

// File: tb/irq_ctrl6_tb.sv
module irq_ctrl6_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_tick = 1'b1;
  logic [1:0] ext_n = 2'b11;
  logic [1:0] ext_type = 2'b00;
  logic       ext2_n = 1'b1;
  logic       ext2_en = 1'b0;
  logic       exf2_clr = 1'b0;
  logic       tmr0_ovf = 1'b0;
  logic       tmr1_ovf = 1'b0;
  logic       ser_rx = 1'b0;
  logic       ser_tx = 1'b0;
  logic       t2_flag = 1'b0;
  logic [5:0] en_mask = 6'b0;
  logic       glob_en = 1'b0;
  logic [5:0] prio_hi = 6'b0;
  logic       ack = 1'b0;
  logic       reti = 1'b0;
  logic       irq_req;
  logic [2:0] irq_idx;
  logic [7:0] irq_addr;
  logic [5:0] pend;

  irq_ctrl6 u_dut (.*);

  always #5 clk = ~clk;

  typedef struct {
    string      tag;
    logic       req;
    logic [2:0] idx;
    logic [5:0] pnd;
  } exp_t;

  exp_t queue_q[$];
  event chk_ev;
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  task automatic expect_out(string tag, logic req, logic [2:0] idx, logic [5:0] pnd);
    exp_t e;
    e.tag = tag; e.req = req; e.idx = idx; e.pnd = pnd;
    queue_q.push_back(e);
    ->chk_ev;
    #1;
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (queue_q.size() > 0) begin
        exp_t e;
        logic [7:0] ea;
        e = queue_q.pop_front();
        ea = 8'(3 + 8 * int'(e.idx));
        n_chk++;
        if (irq_req !== e.req || pend !== e.pnd ||
            (e.req && (irq_idx !== e.idx || irq_addr !== ea))) begin
          n_fail++;
          $display("FAIL %s: req=%0b idx=%0d addr=%h pend=%b expected req=%0b idx=%0d addr=%h pend=%b",
                   e.tag, irq_req, irq_idx, irq_addr, pend, e.req, e.idx, ea, e.pnd);
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1; step(1); reti = 1'b0;
  endtask

  task automatic pulse_t0();
    tmr0_ovf = 1'b1; step(1); tmr0_ovf = 1'b0;
  endtask

  task automatic pulse_t1();
    tmr1_ovf = 1'b1; step(1); tmr1_ovf = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    expect_out("R1 reset", 0, 0, 6'b000000);

    // R7 masking, then enable
    pulse_t0();
    expect_out("R7 masked source", 0, 0, 6'b000010);
    glob_en = 1'b1; en_mask = 6'b111111; step(1);
    expect_out("R7 enabled source", 1, 1, 6'b000010);
    glob_en = 1'b0; step(1);
    expect_out("R7 global off", 0, 0, 6'b000010);
    glob_en = 1'b1; step(1);

    // R4 timer flag cleared by acknowledge
    do_ack();
    expect_out("R4 timer0 cleared", 0, 0, 6'b000000);
    do_reti();

    // R2 level mode with tick gating
    mc_tick = 1'b0; ext_n[0] = 1'b0; step(2);
    expect_out("R2 no tick no sample", 0, 0, 6'b000000);
    mc_tick = 1'b1; step(1);
    expect_out("R2 level low requests", 1, 0, 6'b000001);
    do_ack();
    expect_out("R2 level kept after ack, R10 held off", 0, 0, 6'b000001);
    do_reti();
    expect_out("R2 level requests again", 1, 0, 6'b000001);
    ext_n[0] = 1'b1; step(1);
    expect_out("R2 level released", 0, 0, 6'b000000);

    // R3 edge mode on pin 1
    ext_type = 2'b10;
    ext_n[1] = 1'b0; step(1);
    expect_out("R3 edge sets flag", 1, 2, 6'b000100);
    ext_n[1] = 1'b1; step(1);
    expect_out("R3 flag held after pin high", 1, 2, 6'b000100);
    do_ack();
    expect_out("R3 flag cleared on ack", 0, 0, 6'b000000);
    do_reti();

    // R8 order within the low level, R5 serial kept
    pulse_t1(); ser_rx = 1'b1; step(1);
    expect_out("R8 timer1 before serial", 1, 3, 6'b011000);
    do_ack();
    expect_out("R10 serial held while low active", 0, 0, 6'b010000);
    do_reti();
    expect_out("R8 serial next", 1, 4, 6'b010000);
    do_ack();
    expect_out("R5 serial not cleared by ack", 0, 0, 6'b010000);
    do_reti();
    ser_rx = 1'b0; ser_tx = 1'b1; step(1);
    expect_out("R5 transmit flag requests", 1, 4, 6'b010000);
    ser_tx = 1'b0; step(1);

    // R9 high level wins over lower index
    prio_hi = 6'b010000; ser_rx = 1'b1; pulse_t0();
    expect_out("R9 high serial beats timer0", 1, 4, 6'b010010);
    do_ack();
    expect_out("R10 nothing under high level", 0, 0, 6'b010010);
    do_reti();
    expect_out("R9 high again after reti", 1, 4, 6'b010010);
    ser_rx = 1'b0; step(1);
    expect_out("R9 low timer0 after", 1, 1, 6'b000010);

    // R10 preemption of a low routine
    prio_hi = 6'b100000;
    do_ack();
    expect_out("R10 low in service", 0, 0, 6'b000000);
    pulse_t1();
    expect_out("R10 low request held off", 0, 0, 6'b001000);
    t2_flag = 1'b1; step(1);
    expect_out("R10 high preempts low", 1, 5, 6'b101000);
    do_ack();
    expect_out("R10 both levels active", 0, 0, 6'b101000);
    t2_flag = 1'b0; do_reti();
    expect_out("R10 low still active after one reti", 0, 0, 6'b001000);
    do_reti();
    expect_out("R10 held request after returns", 1, 3, 6'b001000);
    do_ack(); do_reti();

    // R6 third external edge flag
    ext2_n = 1'b0; step(1); ext2_n = 1'b1; step(1);
    expect_out("R6 edge ignored when disabled", 0, 0, 6'b000000);
    ext2_en = 1'b1; ext2_n = 1'b0; step(1); ext2_n = 1'b1; step(1);
    expect_out("R6 edge sets flag", 1, 5, 6'b100000);
    do_ack();
    expect_out("R6 flag kept after ack", 0, 0, 6'b100000);
    do_reti();
    exf2_clr = 1'b1; step(1); exf2_clr = 1'b0;
    expect_out("R6 software clear", 0, 0, 6'b000000);

    // R11 stray acknowledge
    do_ack();
    pulse_t0();
    expect_out("R11 stray ack had no effect", 1, 1, 6'b000010);

    step(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule